// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

An 8-bit up-counter advanced by a count-enable pulse taken from one of eight taps of a free-running 12-bit prescaler. The taps divide the input clock by 32, 64, 128 and so on up to 4096. The counter runs in one of two modes. In watchdog mode, a wrap from 0xFF to 0x00 requests a system reset and reports which reset kind is wanted. In interval mode, the same wrap raises a flag, and that flag drives an interrupt request.

Software reaches the block through a one-address-bit register port. Address 0 is the control/status register. Address 1 is the counter itself, which can be read and reloaded at any time.

Control/status layout: bit 7 run, bit 6 mode (1 watchdog, 0 interval), bit 5 reset kind, bit 4 watchdog overflow flag, bit 3 interval overflow flag, bits 2:0 divide select.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset, both registers read 0, and `rst_req`, `rst_kind` and `irq` are 0.
- R2: While bit 7 is 1, the counter advances by one every 2^(5+S) clocks, where S is bits 2:0 (000 gives 1/32, up to 111 giving 1/4096). The prescaler runs freely from reset.
- R3: While bit 7 is 0, the counter holds its value unless software writes it.
- R4: A write to address 0 while bit 7 is already 1 leaves bits 2:0 unchanged. Bits 7, 6 and 5 are still written.
- R5: In watchdog mode (bit 6 = 1), a wrap from 0xFF to 0x00 sets bit 4. On the next clock, `rst_req` is 1 for exactly one cycle, and `rst_kind` then equals bit 5 (0 power-on, 1 manual). Bit 3 is not set.
- R6: In interval mode (bit 6 = 0), a wrap sets bit 3 and leaves bit 4 unchanged.
- R7: `irq` is 1 exactly while bit 3 is 1 and input `irq_en` is 1.
- R8: Writing 0 to bit 4 or bit 3 clears that flag, and writing 1 leaves it unchanged. An overflow in the same cycle as a clearing write sets the flag.
- R9: A write to address 1 loads `wdata` into the counter. It overrides an increment in the same cycle, and no overflow occurs in that cycle.
- R10: Bit 5 is readable and writable in both modes. In interval mode, overflows never raise `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 control/status, 1 counter |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq_en | input | 1 | Interrupt enable for the interval flag |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 1 | Reset kind of the last request |
| irq | output | 1 | Interval interrupt request |

## Verification
The bench measures the increment spacing for several divide selects. A design that tapped the wrong prescaler bit would show spacing that is off by a factor of two.

It lands counter reloads and control writes on increment cycles. A design that let the increment win, or that let a select change slip in while running, would drift from the reference model.

Overflows are driven in both modes, with both reset kinds, and with clearing writes racing an overflow. This exposes flags set in the wrong mode, reset requests in interval mode, pulses longer than one cycle, and a clear that wins over a set.

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
  parameter int PRE_W    = 12,
  parameter int BASE_LOG = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_en,
  output logic       rst_req,
  output logic       rst_kind,
  output logic       irq
);
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       cnt_q;
  logic [2:0]       sel_q;
  logic             run_q, wdog_q, kind_q, wflag_q, iflag_q;

  logic [PRE_W-1:0] tap_mask;
  logic             tick, wr_ctl, wr_cnt, step, wrap;

  assign tap_mask = (PRE_W'(1) << (BASE_LOG + int'(sel_q))) - PRE_W'(1);
  assign tick     = (pre_q & tap_mask) == tap_mask;
  assign wr_ctl   = wr_en && !addr;
  assign wr_cnt   = wr_en && addr;
  assign step     = run_q && tick && !wr_cnt;
  assign wrap     = step && (cnt_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      sel_q    <= '0;
      run_q    <= 1'b0;
      wdog_q   <= 1'b0;
      kind_q   <= 1'b0;
      wflag_q  <= 1'b0;
      iflag_q  <= 1'b0;
      rst_req  <= 1'b0;
      rst_kind <= 1'b0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (wr_cnt)    cnt_q <= wdata;
      else if (step) cnt_q <= cnt_q + 8'd1;
      if (wr_ctl) begin
        run_q  <= wdata[7];
        wdog_q <= wdata[6];
        kind_q <= wdata[5];
        if (!run_q) sel_q <= wdata[2:0];
      end
      wflag_q <= (wrap && wdog_q)  || (wflag_q && !(wr_ctl && !wdata[4]));
      iflag_q <= (wrap && !wdog_q) || (iflag_q && !(wr_ctl && !wdata[3]));
      rst_req <= wrap && wdog_q;
      if (wrap && wdog_q) rst_kind <= kind_q;
    end
  end

  assign rdata = addr ? cnt_q : {run_q, wdog_q, kind_q, wflag_q, iflag_q, sel_q};
  assign irq   = iflag_q && irq_en;
endmodule

module wdt_interval_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] cnt_q,
  input logic [2:0] sel_q,
  input logic       run_q,
  input logic       wdog_q,
  input logic       kind_q,
  input logic       wflag_q,
  input logic       iflag_q,
  input logic       rst_req,
  input logic       rst_kind
);
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && addr)) |=> cnt_q == $past(cnt_q));
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 8'd1));
  assert_sel_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && !addr) |=> sel_q == $past(sel_q));
  assert_reload_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> cnt_q == $past(wdata));
  assert_req_after_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(wdog_q) && cnt_q == 8'h00 && wflag_q && $past(cnt_q) == 8'hFF));
  assert_req_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rst_kind == $past(kind_q));
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_iflag_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag_q) |-> (!$past(wdog_q) && cnt_q == 8'h00));
endmodule

bind wdt_interval_timer wdt_interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt_q(cnt_q), .sel_q(sel_q), .run_q(run_q), .wdog_q(wdog_q), .kind_q(kind_q),
  .wflag_q(wflag_q), .iflag_q(iflag_q), .rst_req(rst_req), .rst_kind(rst_kind)
);

// File: tb/tb_wdt_interval_timer.sv
module tb_wdt_interval_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0, irq_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rst_req, rst_kind, irq;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  wdt_interval_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .rst_req(rst_req),
    .rst_kind(rst_kind), .irq(irq));

  logic [11:0] m_pre;
  logic [7:0]  m_cnt;
  logic [2:0]  m_sel;
  logic m_run, m_wd, m_kind, m_wf, m_if, m_req, m_rk;

  function automatic logic m_tick(logic [11:0] p, logic [2:0] s);
    int per = 1 << (5 + s);
    return (int'(p) % per) == per - 1;
  endfunction

  function automatic logic [7:0] m_ctl();
    return {m_run, m_wd, m_kind, m_wf, m_if, m_sel};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_sel <= 0; m_run <= 0; m_wd <= 0; m_kind <= 0;
      m_wf <= 0; m_if <= 0; m_req <= 0; m_rk <= 0;
    end else begin
      logic inc, ov;
      cyc <= cyc + 1;
      inc = m_run && m_tick(m_pre, m_sel) && !(wr_en && addr);
      ov  = inc && m_cnt == 8'hFF;
      m_pre <= m_pre + 1;
      if (wr_en && addr) m_cnt <= wdata;
      else if (inc) m_cnt <= m_cnt + 1;
      if (wr_en && !addr) begin
        m_run <= wdata[7]; m_wd <= wdata[6]; m_kind <= wdata[5];
        if (!m_run) m_sel <= wdata[2:0];
      end
      m_wf <= (ov && m_wd) || (m_wf && !(wr_en && !addr && !wdata[4]));
      m_if <= (ov && !m_wd) || (m_if && !(wr_en && !addr && !wdata[3]));
      m_req <= ov && m_wd;
      if (ov && m_wd) m_rk <= m_kind;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    if (addr) chk(rdata == m_cnt, "R2 count", rdata, m_cnt);
    else      chk(rdata == m_ctl(), "R8 ctrl", rdata, m_ctl());
    chk(rst_req == m_req, "R5 rst_req", rst_req, m_req);
    chk(rst_kind == m_rk, "R10 rst_kind", rst_kind, m_rk);
    chk(irq == (m_if && irq_en), "R7 irq", irq, m_if && irq_en);
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(posedge clk); #1 addr = a; @(negedge clk); v = rdata;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<190000", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    bit seen;
    int t1, t2, dummy;
    dummy = $urandom(32'h5EED1);
    #7 rst_n = 1;
    @(negedge clk);
    chk(rdata == 8'h00, "R1 ctrl", rdata, 0);
    chk(!rst_req && !rst_kind && !irq, "R1 outputs", {rst_req, rst_kind, irq}, 0);
    rd(1'b1, v); chk(v == 8'h00, "R1 count", v, 0);
    cmp_on = 1;

    idle(200); rd(1'b1, v); chk(v == 8'h00, "R3 stopped hold", v, 0);

    for (int s = 0; s < 4; s++) begin
      wr(1'b0, 8'h00 | 8'(s)); wr(1'b1, 8'h00); wr(1'b0, 8'h80 | 8'(s));
      addr = 1;
      @(negedge clk); v = rdata;
      while (rdata == v) @(negedge clk);
      t1 = cyc; v = rdata;
      while (rdata == v) @(negedge clk);
      t2 = cyc;
      chk(t2 - t1 == (1 << (5 + s)), "R2 spacing", t2 - t1, 1 << (5 + s));
    end

    wr(1'b0, 8'h87); rd(1'b0, v); chk(v[2:0] == 3'd3, "R4 sel locked", v[2:0], 3);
    wr(1'b0, 8'h00); wr(1'b0, 8'h01); rd(1'b0, v); chk(v[2:0] == 3'd1, "R4 sel stopped", v[2:0], 1);

    wr(1'b0, 8'h20); wr(1'b1, 8'hFD); wr(1'b0, 8'hE0);
    wait_req(seen); chk(seen, "R5 rst_req seen", seen, 1);
    chk(rst_kind == 1'b1, "R10 manual kind", rst_kind, 1);
    @(negedge clk); chk(!rst_req, "R5 single pulse", rst_req, 0);
    rd(1'b0, v); chk(v[4:3] == 2'b10, "R5 flags", v[4:3], 2'b10);
    wr(1'b0, 8'hF8); rd(1'b0, v); chk(v[4] == 1'b1, "R8 write1 keeps", v[4], 1);
    wr(1'b0, 8'h40); rd(1'b0, v); chk(v[4] == 1'b0, "R8 write0 clears", v[4], 0);
    wr(1'b1, 8'hFE); wr(1'b0, 8'hC0);
    wait_req(seen); chk(seen && rst_kind == 1'b0, "R5 power-on kind", rst_kind, 0);

    wr(1'b0, 8'h20); wr(1'b1, 8'hFE); irq_en = 1; wr(1'b0, 8'hA0);
    wait_req(seen); chk(!seen, "R10 no req interval", seen, 0);
    rd(1'b0, v); chk(v[4:3] == 2'b01, "R6 interval flag", v[4:3], 2'b01);
    chk(irq == 1'b1, "R7 irq on", irq, 1);
    irq_en = 0; @(negedge clk); chk(irq == 1'b0, "R7 irq masked", irq, 0);
    wr(1'b1, 8'h10); rd(1'b1, v); chk(v == 8'h10, "R9 reload", v, 8'h10);

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      irq_en = 1'($urandom);
      if ($urandom % 3 == 0) d[2:0] = d[2:0] & 3'b001;
      if ($urandom % 4 == 0) wr(1'b1, 8'hF0 | d[3:0]);
      else wr(1'($urandom), d);
      for (int k = $urandom % 60; k > 0; k--) begin
        @(posedge clk); #1 addr = 1'($urandom);
      end
    end

    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule